// File: doc/BRIEF.md
# Stream Queue Index and Address Unit

This block keeps the pointer state for one stream queue of a processor that has no load or store instructions. Software reaches memory only through a data window paired with an index. The block holds the index, which is a 56-bit byte address topped by an 8-bit memory-type tag. It also holds a queue base, a queue limit, signed read and write steps, and a small property word. Each access to the data window can move the index by a step scaled by the operand size. With circular addressing on, an index that runs past the limit folds back to the base.

Writing the index starts a fresh fetch and drops any check still in flight. One cycle after the write, the block checks the new pointer. In unprotected mode the tag names the physical memory directly and only the queue limit applies. In protected mode the tag selects an entry in a 256-entry translation table. That entry gives a physical memory type, a physical base and a logical limit. When no check fails, the block issues a one-cycle fetch request with the translated address. Errors stay as sticky status bits until the index is written again. The queue storage, the memory bus and trap delivery belong to the blocks around it.

Top module: `sq_addr_gen`

## Requirements
- R1: With property bit 0 (auto-step) set, a data-window read adds the signed read step times the operand size in bytes to the index address. The new index is visible one cycle after the access, and the type tag is unchanged.
- R2: With auto-step set, a data-window write adds the signed write step times the operand size in bytes to the index address.
- R3: When a read and a write of the data window arrive in the same cycle, the index moves once, by the write step only.
- R4: The operand size code is 0, 1, 2 or 3 and selects 1, 2, 4 or 8 bytes. Steps are two's complement, so a negative step moves the index downward.
- R5: With auto-step clear, data-window accesses leave the index unchanged.
- R6: With property bit 1 (circular) set, a stepped address greater than the queue limit is replaced by the queue base. An address equal to the limit is kept.
- R7: An index write with size code 3 replaces all 64 bits: address bits 55..0 and tag bits 63..56. Size codes 0, 1 and 2 replace only the low 8, 16 or 32 address bits and keep the tag. An index write in the same cycle as a data access takes precedence, and the access has no effect.
- R8: Two cycles after an index write that passes all checks, fetch request pulses for one cycle and the status reads 4'b1000 (bit 3 = ready). With property bit 2 (protected) clear, the fetch type is the tag and the fetch address is the index address.
- R9: With protected set, the tag indexes the translation table. The fetch type is the entry's physical type, and the fetch address is the entry's base plus the index address.
- R10: The index check sets status bit 0 when protected is set and the table entry is invalid. It sets bit 1 when the address is greater than the queue limit. It sets bit 2 when protected is set and the address is greater than the entry's limit. Any of these errors blocks the fetch and leaves ready clear.
- R11: A data-window access while the index address is greater than the queue limit pulses the data error output in the next cycle and sets status bit 1.
- R12: An index write clears all status bits in the next cycle. An index write during the check cycle of an earlier write cancels the earlier fetch, so only the later write fetches.
- R13: After reset the index, status and outputs are zero and every table entry is invalid. Config select codes are 0 base, 1 limit, 2 read step, 3 write step and 4 properties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 3 | Config register select |
| cfg_wdata | input | 64 | Config write data |
| tbl_we | input | 1 | Translation table write strobe |
| tbl_addr | input | 8 | Table entry written |
| tbl_valid | input | 1 | Entry valid bit |
| tbl_ptype | input | 8 | Entry physical memory type |
| tbl_base | input | 56 | Entry physical base |
| tbl_limit | input | 56 | Entry logical limit |
| idx_we | input | 1 | Index write strobe |
| idx_size | input | 2 | Index write size code |
| idx_wdata | input | 64 | Index write data |
| dat_rd | input | 1 | Data window read this cycle |
| dat_wr | input | 1 | Data window write this cycle |
| dat_size | input | 2 | Operand size code of the access |
| index_o | output | 64 | Current tag and address |
| status_o | output | 4 | Sticky error bits and ready |
| data_err_o | output | 1 | Out-of-bound data access pulse |
| fetch_req_o | output | 1 | Fetch request pulse |
| fetch_addr_o | output | 56 | Physical fetch address |
| fetch_type_o | output | 8 | Physical memory type of the fetch |

## Verification
The assertions check several rules on every cycle. A fetch never coexists with an error bit. Fetches never come in back-to-back cycles. An index write always clears the status and suppresses the fetch of the next cycle. Unprotected fetches carry the pointer's own tag. Out-of-bound accesses always raise the data error. With auto-step off, the index holds still under data accesses. The arithmetic itself can only be shown by the bench's scenarios: scaled and signed steps, write-over-read priority, the fold back to the base, narrow index merges and the protected translation of base and limit.

// File: rtl/sqag_pkg.sv
package sqag_pkg;
  localparam int PTR_W   = 64;
  localparam int TYPE_W  = 8;
  localparam int ADDR_W  = PTR_W - TYPE_W;
  localparam int TBL_N   = 1 << TYPE_W;
  localparam int ST_W    = 4;

  // status bit positions
  localparam int ST_BADTYPE = 0;
  localparam int ST_QLIM    = 1;
  localparam int ST_MLIM    = 2;
  localparam int ST_RDY     = 3;

  // config select codes
  localparam logic [2:0] SEL_BASE  = 3'd0;
  localparam logic [2:0] SEL_LIMIT = 3'd1;
  localparam logic [2:0] SEL_RINC  = 3'd2;
  localparam logic [2:0] SEL_WINC  = 3'd3;
  localparam logic [2:0] SEL_PROPS = 3'd4;

  // property bit positions
  localparam int PR_AUTO = 0;
  localparam int PR_CIRC = 1;
  localparam int PR_PROT = 2;
  localparam int PR_W    = 3;

  typedef struct packed {
    logic              valid;
    logic [TYPE_W-1:0] ptype;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } xl_entry_t;
endpackage

// File: rtl/sqag_xlate.sv
module sqag_xlate
  import sqag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [TYPE_W-1:0] waddr_i,
  input  xl_entry_t         wentry_i,
  input  logic [TYPE_W-1:0] raddr_i,
  output xl_entry_t         rentry_o
);
  logic [TBL_N-1:0] vld_q;
  logic [TYPE_W+2*ADDR_W-1:0] body_q [TBL_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (we_i) begin
      vld_q[waddr_i] <= wentry_i.valid;
    end
  end

  always_ff @(posedge clk) begin
    if (we_i) begin
      body_q[waddr_i] <= {wentry_i.ptype, wentry_i.base, wentry_i.limit};
    end
  end

  always_comb begin
    rentry_o       = '{valid: vld_q[raddr_i], ptype: '0, base: '0, limit: '0};
    {rentry_o.ptype, rentry_o.base, rentry_o.limit} = body_q[raddr_i];
  end
endmodule

// File: rtl/sqag_step.sv
module sqag_step
  import sqag_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic [1:0]        size_i,
  input  logic              circ_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - INC_W;

  logic [ADDR_W-1:0] inc_ext;
  logic [ADDR_W-1:0] delta;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    inc_ext = {{EXT_W{inc_i[INC_W-1]}}, inc_i};
    delta   = inc_ext << size_i;
    sum     = addr_i + delta;
    addr_o  = (circ_i && (sum > limit_i)) ? base_i : sum;
  end
endmodule

// File: rtl/sqag_check.sv
module sqag_check
  import sqag_pkg::*;
(
  input  logic              prot_i,
  input  logic [TYPE_W-1:0] type_i,
  input  xl_entry_t         entry_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] qlimit_i,
  output logic [2:0]        err_o,
  output logic [TYPE_W-1:0] ptype_o,
  output logic [ADDR_W-1:0] pbase_o
);
  always_comb begin
    err_o             = '0;
    err_o[ST_BADTYPE] = prot_i && !entry_i.valid;
    err_o[ST_QLIM]    = addr_i > qlimit_i;
    err_o[ST_MLIM]    = prot_i && entry_i.valid && (addr_i > entry_i.limit);
    ptype_o           = prot_i ? entry_i.ptype : type_i;
    pbase_o           = prot_i ? entry_i.base  : '0;
  end
endmodule

// File: rtl/sq_addr_gen.sv
module sq_addr_gen
  import sqag_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [PTR_W-1:0]  cfg_wdata,
  input  logic              tbl_we,
  input  logic [TYPE_W-1:0] tbl_addr,
  input  logic              tbl_valid,
  input  logic [TYPE_W-1:0] tbl_ptype,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_limit,
  input  logic              idx_we,
  input  logic [1:0]        idx_size,
  input  logic [PTR_W-1:0]  idx_wdata,
  input  logic              dat_rd,
  input  logic              dat_wr,
  input  logic [1:0]        dat_size,
  output logic [PTR_W-1:0]  index_o,
  output logic [ST_W-1:0]   status_o,
  output logic              data_err_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [TYPE_W-1:0] fetch_type_o
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // configuration registers
  logic [ADDR_W-1:0] base_q, limit_q;
  logic [INC_W-1:0]  rinc_q, winc_q;
  logic [PR_W-1:0]   props_q;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[PTR_W-1:ADDR_W]};

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      base_q  <= '0;
      limit_q <= '0;
      rinc_q  <= '0;
      winc_q  <= '0;
      props_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BASE:  base_q  <= cfg_wdata[ADDR_W-1:0];
        SEL_LIMIT: limit_q <= cfg_wdata[ADDR_W-1:0];
        SEL_RINC:  rinc_q  <= cfg_wdata[INC_W-1:0];
        SEL_WINC:  winc_q  <= cfg_wdata[INC_W-1:0];
        SEL_PROPS: props_q <= cfg_wdata[PR_W-1:0];
        default:   ;
      endcase
    end
  end

  // pointer and pipeline state
  logic [ADDR_W-1:0] idx_addr_q, idx_addr_d;
  logic [TYPE_W-1:0] idx_type_q, idx_type_d;
  logic              chk_pend_q, chk_pend_d;
  logic [ST_W-1:0]   status_q, status_d;
  logic              fetch_req_q, fetch_req_d;
  logic [ADDR_W-1:0] fetch_addr_q, fetch_addr_d;
  logic [TYPE_W-1:0] fetch_type_q, fetch_type_d;
  logic              data_err_q, data_err_d;

  // sub-blocks
  xl_entry_t         tbl_wentry, xl_entry;
  logic [INC_W-1:0]  sel_inc;
  logic [ADDR_W-1:0] step_addr;
  logic [2:0]        chk_err;
  logic [TYPE_W-1:0] phys_type;
  logic [ADDR_W-1:0] phys_base;

  assign tbl_wentry = '{valid: tbl_valid, ptype: tbl_ptype, base: tbl_base, limit: tbl_limit};
  assign sel_inc    = dat_wr ? winc_q : rinc_q;

  sqag_xlate u_tbl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we_i     (tbl_we),
    .waddr_i  (tbl_addr),
    .wentry_i (tbl_wentry),
    .raddr_i  (idx_type_q),
    .rentry_o (xl_entry)
  );

  sqag_step #(.INC_W(INC_W)) u_step (
    .addr_i  (idx_addr_q),
    .inc_i   (sel_inc),
    .size_i  (dat_size),
    .circ_i  (props_q[PR_CIRC]),
    .base_i  (base_q),
    .limit_i (limit_q),
    .addr_o  (step_addr)
  );

  sqag_check u_chk_logic (
    .prot_i   (props_q[PR_PROT]),
    .type_i   (idx_type_q),
    .entry_i  (xl_entry),
    .addr_i   (idx_addr_q),
    .qlimit_i (limit_q),
    .err_o    (chk_err),
    .ptype_o  (phys_type),
    .pbase_o  (phys_base)
  );

  // next-state logic
  always_comb begin
    idx_addr_d   = idx_addr_q;
    idx_type_d   = idx_type_q;
    chk_pend_d   = 1'b0;
    status_d     = status_q;
    fetch_req_d  = 1'b0;
    fetch_addr_d = fetch_addr_q;
    fetch_type_d = fetch_type_q;
    data_err_d   = 1'b0;

    if (idx_we) begin
      case (idx_size)
        2'd0: idx_addr_d = {idx_addr_q[ADDR_W-1:8],  idx_wdata[7:0]};
        2'd1: idx_addr_d = {idx_addr_q[ADDR_W-1:16], idx_wdata[15:0]};
        2'd2: idx_addr_d = {idx_addr_q[ADDR_W-1:32], idx_wdata[31:0]};
        default: begin
          idx_addr_d = idx_wdata[ADDR_W-1:0];
          idx_type_d = idx_wdata[PTR_W-1:ADDR_W];
        end
      endcase
      status_d   = '0;
      chk_pend_d = 1'b1;
    end else begin
      if (chk_pend_q) begin
        status_d[2:0]   = status_q[2:0] | chk_err;
        status_d[ST_RDY] = (chk_err == 3'b000);
        if (chk_err == 3'b000) begin
          fetch_req_d  = 1'b1;
          fetch_addr_d = phys_base + idx_addr_q;
          fetch_type_d = phys_type;
        end
      end
      if (dat_rd || dat_wr) begin
        if (chk_err[ST_QLIM]) begin
          data_err_d        = 1'b1;
          status_d[ST_QLIM] = 1'b1;
        end
        if (props_q[PR_AUTO]) begin
          idx_addr_d = step_addr;
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_addr_q   <= '0;
      idx_type_q   <= '0;
      chk_pend_q   <= 1'b0;
      status_q     <= '0;
      fetch_req_q  <= 1'b0;
      fetch_addr_q <= '0;
      fetch_type_q <= '0;
      data_err_q   <= 1'b0;
    end else begin
      idx_addr_q   <= idx_addr_d;
      idx_type_q   <= idx_type_d;
      chk_pend_q   <= chk_pend_d;
      status_q     <= status_d;
      fetch_req_q  <= fetch_req_d;
      fetch_addr_q <= fetch_addr_d;
      fetch_type_q <= fetch_type_d;
      data_err_q   <= data_err_d;
    end
  end

  assign index_o      = {idx_type_q, idx_addr_q};
  assign status_o     = status_q;
  assign data_err_o   = data_err_q;
  assign fetch_req_o  = fetch_req_q;
  assign fetch_addr_o = fetch_addr_q;
  assign fetch_type_o = fetch_type_q;
endmodule

// File: rtl/sqag_props.sv
module sqag_props
  import sqag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              dat_rd,
  input  logic              dat_wr,
  input  logic              auto_en,
  input  logic              prot_en,
  input  logic [ADDR_W-1:0] qlimit,
  input  logic [PTR_W-1:0]  index,
  input  logic [ST_W-1:0]   status,
  input  logic              data_err,
  input  logic              fetch_req,
  input  logic [TYPE_W-1:0] fetch_type
);
  // R8 R10
  fetch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (status == 4'b1000));

  // R12
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  // R12
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (status == 4'b0000) && !fetch_req);

  // R8
  unprot_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !prot_en) |-> (fetch_type == index[PTR_W-1:ADDR_W]));

  // R11
  data_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_rd || dat_wr) && !idx_we && (index[ADDR_W-1:0] > qlimit))
      |=> (data_err && status[ST_QLIM]));

  // R5
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_rd || dat_wr) && !idx_we && !auto_en) |=> $stable(index));
endmodule

bind sq_addr_gen sqag_props u_props (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .idx_we     (idx_we),
  .dat_rd     (dat_rd),
  .dat_wr     (dat_wr),
  .auto_en    (props_q[0]),
  .prot_en    (props_q[2]),
  .qlimit     (limit_q),
  .index      (index_o),
  .status     (status_o),
  .data_err   (data_err_o),
  .fetch_req  (fetch_req_o),
  .fetch_type (fetch_type_o)
);

// File: tb/tb_sq_addr_gen.sv
`timescale 1ns/1ps
module tb_sq_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic        tbl_valid = 1'b0;
  logic [7:0]  tbl_ptype = '0;
  logic [55:0] tbl_base = '0;
  logic [55:0] tbl_limit = '0;
  logic        idx_we = 1'b0;
  logic [1:0]  idx_size = '0;
  logic [63:0] idx_wdata = '0;
  logic        dat_rd = 1'b0;
  logic        dat_wr = 1'b0;
  logic [1:0]  dat_size = '0;
  logic [63:0] index_o;
  logic [3:0]  status_o;
  logic        data_err_o;
  logic        fetch_req_o;
  logic [55:0] fetch_addr_o;
  logic [7:0]  fetch_type_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  sq_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid), .tbl_ptype(tbl_ptype),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit), .idx_we(idx_we), .idx_size(idx_size),
    .idx_wdata(idx_wdata), .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_size(dat_size),
    .index_o(index_o), .status_o(status_o), .data_err_o(data_err_o),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_type_o(fetch_type_o)
  );

  typedef struct packed {
    logic        auto_en;
    logic        circ;
    logic        rd;
    logic        wr;
    logic [1:0]  sz;
    logic [15:0] ri;
    logic [15:0] wi;
    logic [63:0] start;
    logic [63:0] expv;
  } vec_t;

  // base 0x100, limit 0x1000, tag 0x05
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 16'd3,     16'd0,     64'h0500_0000_0000_0200, 64'h0500_0000_0000_020C}, // R1 R4
    '{1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 16'd0,     16'd2,     64'h0500_0000_0000_0200, 64'h0500_0000_0000_0210}, // R2 R4
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 16'd5,     16'hFFFF,  64'h0500_0000_0000_0200, 64'h0500_0000_0000_01FE}, // R3
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 16'hFFFC,  16'd0,     64'h0500_0000_0000_0200, 64'h0500_0000_0000_01FC}, // R4
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 16'd7,     16'd0,     64'h0500_0000_0000_0200, 64'h0500_0000_0000_0200}, // R5
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 16'd1,     16'd0,     64'h0500_0000_0000_0FFC, 64'h0500_0000_0000_0100}, // R6
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 16'd0,     16'd2,     64'h0500_0000_0000_0FF8, 64'h0500_0000_0000_1000}, // R6
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 16'd1,     16'd0,     64'h0500_0000_0000_0FFC, 64'h0500_0000_0000_1004}  // R6
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [63:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idx_wr(input logic [1:0] sz, input logic [63:0] val);
    idx_we = 1'b1; idx_size = sz; idx_wdata = val;
    @(negedge clk);
    idx_we = 1'b0;
  endtask

  task automatic tbl_wr(input logic [7:0] a, input logic v, input logic [7:0] pt,
                        input logic [55:0] b, input logic [55:0] l);
    tbl_we = 1'b1; tbl_addr = a; tbl_valid = v; tbl_ptype = pt; tbl_base = b; tbl_limit = l;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    check("R13 index", index_o, 64'h0);
    check("R13 status", {60'h0, status_o}, 64'h0);
    check("R13 fetch", {63'h0, fetch_req_o}, 64'h0);

    cfg(3'd0, 64'h100);
    cfg(3'd1, 64'h1000);

    // table of stepping vectors
    for (int i = 0; i < 8; i++) begin
      cfg(3'd4, {61'h0, 1'b0, VECS[i].circ, VECS[i].auto_en});
      cfg(3'd2, {48'h0, VECS[i].ri});
      cfg(3'd3, {48'h0, VECS[i].wi});
      idx_wr(2'd3, VECS[i].start);
      @(negedge clk);
      dat_rd = VECS[i].rd; dat_wr = VECS[i].wr; dat_size = VECS[i].sz;
      @(negedge clk);
      dat_rd = 1'b0; dat_wr = 1'b0;
      check($sformatf("R1-6 vector %0d (R1 R2 R3 R4 R5 R6)", i), index_o, VECS[i].expv);
    end

    // R8 unprotected fetch
    cfg(3'd4, 64'h0);
    idx_wr(2'd3, 64'h0700_0000_0000_0300);
    check("R12 no fetch in check cycle", {63'h0, fetch_req_o}, 64'h0);
    @(negedge clk);
    check("R8 fetch req", {63'h0, fetch_req_o}, 64'h1);
    check("R8 fetch addr", {8'h0, fetch_addr_o}, 64'h300);
    check("R8 fetch type", {56'h0, fetch_type_o}, 64'h07);
    check("R8 status ready", {60'h0, status_o}, 64'h8);
    @(negedge clk);
    check("R8 single pulse", {63'h0, fetch_req_o}, 64'h0);

    // R10 queue limit error, R11 data error
    idx_wr(2'd3, 64'h0700_0000_0000_2000);
    @(negedge clk);
    check("R10 qlim status", {60'h0, status_o}, 64'h2);
    check("R10 no fetch", {63'h0, fetch_req_o}, 64'h0);
    dat_rd = 1'b1; dat_size = 2'd0;
    @(negedge clk);
    dat_rd = 1'b0;
    check("R11 data err", {63'h0, data_err_o}, 64'h1);
    check("R11 status", {60'h0, status_o}, 64'h2);
    check("R5 index still", index_o, 64'h0700_0000_0000_2000);
    idx_wr(2'd3, 64'h0700_0000_0000_0040);
    check("R12 status cleared", {60'h0, status_o}, 64'h0);
    @(negedge clk);

    // R9 protected translation
    tbl_wr(8'h09, 1'b1, 8'h33, 56'h1_0000, 56'h800);
    cfg(3'd4, 64'h4);
    idx_wr(2'd3, 64'h0900_0000_0000_0400);
    @(negedge clk);
    check("R9 fetch addr", {8'h0, fetch_addr_o}, 64'h1_0400);
    check("R9 fetch type", {56'h0, fetch_type_o}, 64'h33);
    check("R9 status", {60'h0, status_o}, 64'h8);
    idx_wr(2'd3, 64'h0900_0000_0000_0900);
    @(negedge clk);
    check("R10 mlim status", {60'h0, status_o}, 64'h4);
    check("R10 mlim no fetch", {63'h0, fetch_req_o}, 64'h0);
    idx_wr(2'd3, 64'h0A00_0000_0000_0100);
    @(negedge clk);
    check("R10 bad type status", {60'h0, status_o}, 64'h1);

    // R7 narrow index writes
    idx_wr(2'd3, 64'h0900_0012_3456_7890);
    idx_wr(2'd0, 64'hFFFF_FFFF_FFFF_FFEE);
    check("R7 byte merge", index_o, 64'h0900_0012_3456_78EE);
    idx_wr(2'd1, 64'hFFFF_FFFF_FFFF_0123);
    check("R7 half merge", index_o, 64'h0900_0012_3456_0123);
    idx_wr(2'd2, 64'hFFFF_FFFF_0000_0456);
    check("R7 word merge", index_o, 64'h0900_0012_0000_0456);
    @(negedge clk);

    // R12 cancel: back-to-back index writes
    idx_wr(2'd3, 64'h0900_0000_0000_0400);
    idx_wr(2'd3, 64'h0900_0000_0000_0500);
    check("R12 first fetch cancelled", {63'h0, fetch_req_o}, 64'h0);
    @(negedge clk);
    check("R12 second fetch", {63'h0, fetch_req_o}, 64'h1);
    check("R12 second addr", {8'h0, fetch_addr_o}, 64'h1_0500);

    // R7 index write wins over data access
    cfg(3'd4, 64'h5);
    cfg(3'd2, 64'h1);
    idx_we = 1'b1; idx_size = 2'd3; idx_wdata = 64'h0900_0000_0000_0700;
    dat_rd = 1'b1; dat_size = 2'd3;
    @(negedge clk);
    idx_we = 1'b0; dat_rd = 1'b0;
    check("R7 index write priority", index_o, 64'h0900_0000_0000_0700);
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule